// File: doc/BRIEF.md
# IDE Host Register Bank and Access-Timing Front End

This block sits between a 32-bit processor bus and the PIO transaction engine of an IDE/ATA host controller. It decodes each bus request into one of two windows. The first is a small bank of host-internal registers: control, status, PIO timing, two fast-PIO timing words, two DMA timing words and a transfer buffer. The second is a pass-through window onto the drive's own task-file registers. Host-internal accesses always complete in a fixed two cycles. A device access is handed to the downstream engine through a valid/ready handshake, and the bus waits until that engine answers.

For every device access the block chooses one timing word and passes it to the engine along with the access. A data-register access uses the fast-PIO word of whichever drive is currently selected. Any other device access uses the general PIO word. The block learns which drive is selected by watching software's writes to the device/head register. It also drives the drives' hardware-reset line, keeps the interrupt-status flag, and hides some registers from readback according to a build-time feature level.

Bus protocol: the master raises `bus_valid` and holds `bus_we`, `bus_addr` and `bus_wdata` stable until it sees `bus_ready`. The transfer completes on the clock edge where both are high, and `bus_rdata` is valid in that cycle. A new request is accepted no earlier than the cycle after a completion. On the engine side, `dev_valid` and the request fields stay stable until `dev_ready` is sampled high. `dev_rdata` is taken in that same cycle, and `dev_ready` passes straight through to `bus_ready`.

Top module: `ide_reg_front`

## Requirements
- R1: After reset the following hold. Control reads 0x00000001, so `dev_rst` is 1. Status reads {LEVEL[3:0], REV[3:0], 24'h0}, which is 0x31000000 with the defaults LEVEL=3 and REV=1. The PIO word and both fast words read 0x17021C06 (Teoc 23 in [31:24], T4 2 in [23:16], T2 28 in [15:8], T1 6 in [7:0]). Both DMA words read 0x15001504 (Teoc 21 in [31:24], Td 21 in [15:8], Tm 4 in [7:0]). `irq_out`, `dev_valid` and `bus_ready` are 0.
- R2: Control (offset 0x00) takes effect on the completing edge of a write. Bit 0 drives `dev_rst` directly. Bit 1 enables the interrupt output. Bit 7 enables forwarding to the device window.
- R3: A status write (offset 0x04) changes only bit 0, the interrupt flag. The new flag is the old flag ANDed with written bit 0. The ID and revision fields ignore writes.
- R4: An access to the host window (`bus_addr[6]` = 0) raises `bus_ready` in the second cycle of the request, so there is exactly one wait cycle.
- R5: With forwarding enabled, an access with `bus_addr[6]` = 1 raises `dev_valid` one cycle after acceptance. `dev_addr` equals `bus_addr`, and `dev_valid` holds until `dev_ready`. `bus_ready` rises in the `dev_ready` cycle, and `bus_rdata` then equals `dev_rdata`.
- R6: With forwarding disabled, a device-window access never raises `dev_valid`. It completes in two cycles like a host access; a read returns 0 and a write is dropped.
- R7: When LEVEL is 2 or more, a device access to the data register (device address 0x40) carries fast word 1 (offset 0x10) on `dev_timing` if the drive-select bit is 1, and fast word 0 (offset 0x0C) otherwise. Every other device access, and every access when LEVEL is below 2, carries the PIO word (offset 0x08).
- R8: The drive-select bit resets to 0. It takes bit 4 of each forwarded write to the device/head register (device address 0x58). Dropped writes do not change it.
- R9: Readback follows the feature level. PIO at 0x08 and the transfer buffer write port at 0x1C always store. The fast words at 0x0C and 0x10 read back only when LEVEL is 2 or more. The DMA words at 0x14 and 0x18 and the buffer at 0x1C read back only when LEVEL is 3 or more. Hidden and unmapped host offsets read 0.
- R10: `dev_irq` sets the interrupt flag on the next edge, and a set on the same edge as a clearing status write takes precedence. `irq_out` is high while the flag and control bit 1 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus request present |
| bus_ready | output | 1 | Bus request completes this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address; bit 6 selects the device window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| dev_valid | output | 1 | Device access request to the engine |
| dev_ready | input | 1 | Engine completes the device access |
| dev_we | output | 1 | Device access direction |
| dev_addr | output | 7 | Device register address |
| dev_wdata | output | 32 | Device write data |
| dev_rdata | input | 32 | Device read data, valid with dev_ready |
| dev_timing | output | 32 | Timing word chosen for this access |
| dev_irq | input | 1 | Interrupt request from the drive |
| dev_rst | output | 1 | Hardware reset to the drives |
| irq_out | output | 1 | Interrupt to the processor |

## Verification
A host-window access, or a device-window access with forwarding off, owes `bus_ready` exactly one cycle after the accepting edge. The bench drives each request at a falling edge and counts the falling edges until ready; that count must be 1. A forwarded access owes ready in the cycle the engine model answers. The model answers after a fixed latency, so the count must be that latency plus one. Register writes, `dev_rst`, the drive-select bit and the interrupt flag all change on the completing or setting edge, so each of them is sampled at the next falling edge. A second instance built at feature level 1 shares the stimulus, so its hidden readback and its PIO-only timing choice can be compared against the default instance in the same cycle.

// File: rtl/ide_reg_pkg.sv
package ide_reg_pkg;
  localparam int DW = 32;
  localparam int AW = 7;
  localparam int OW = 6;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_HOST, SEQ_DEV} seq_state_e;

  // host window offsets (byte addresses, bus_addr[6] = 0)
  localparam logic [OW-1:0] OFS_CTRL  = 6'h00;
  localparam logic [OW-1:0] OFS_STAT  = 6'h04;
  localparam logic [OW-1:0] OFS_PIO   = 6'h08;
  localparam logic [OW-1:0] OFS_FAST0 = 6'h0C;
  localparam logic [OW-1:0] OFS_FAST1 = 6'h10;
  localparam logic [OW-1:0] OFS_DMA0  = 6'h14;
  localparam logic [OW-1:0] OFS_DMA1  = 6'h18;
  localparam logic [OW-1:0] OFS_XBUF  = 6'h1C;

  // control bits
  localparam int CTRL_RST_BIT = 0;
  localparam int CTRL_IEN_BIT = 1;
  localparam int CTRL_EN_BIT  = 7;

  // device window addresses that the block decodes
  localparam logic [AW-1:0] DEV_DATA_ADDR = 7'h40;
  localparam logic [AW-1:0] DEV_HEAD_ADDR = 7'h58;
  localparam int HEAD_DRV_BIT = 4;

  function automatic logic [DW-1:0] pio_word(logic [7:0] t1, logic [7:0] t2,
                                             logic [7:0] t4, logic [7:0] teoc);
    return {teoc, t4, t2, t1};
  endfunction

  function automatic logic [DW-1:0] dma_word(logic [7:0] tm, logic [7:0] td,
                                             logic [7:0] teoc);
    return {teoc, 8'h00, td, tm};
  endfunction

  localparam logic [DW-1:0] PIO_MODE0 = pio_word(8'd6, 8'd28, 8'd2, 8'd23);
  localparam logic [DW-1:0] DMA_MODE0 = dma_word(8'd4, 8'd21, 8'd21);
endpackage

// File: rtl/ide_bus_seq.sv
module ide_bus_seq
  import ide_reg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bus_valid,
  input  logic bus_we,
  input  logic is_host,
  input  logic fwd_en,
  input  logic dev_ready,
  output logic bus_ready,
  output logic dev_valid,
  output logic host_wr,
  output logic dev_done
);
  seq_state_e state_q;
  logic go_dev;

  assign go_dev = !is_host && fwd_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (bus_valid) state_q <= go_dev ? SEQ_DEV : SEQ_HOST;
        SEQ_HOST: state_q <= SEQ_IDLE;
        SEQ_DEV:  if (dev_ready) state_q <= SEQ_IDLE;
        default:  state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign dev_valid = (state_q == SEQ_DEV);
  assign bus_ready = (state_q == SEQ_HOST) || (dev_valid && dev_ready);
  assign host_wr   = (state_q == SEQ_HOST) && bus_we && is_host;
  assign dev_done  = dev_valid && dev_ready;

  // R4
  fixed_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_IDLE && bus_valid && !go_dev) |=> bus_ready);

  // R5
  dev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_valid && !dev_ready) |=> dev_valid);

  // R6
  no_fwd_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_IDLE && bus_valid && !fwd_en) |=> !dev_valid);
endmodule

// File: rtl/ide_reg_file.sv
module ide_reg_file
  import ide_reg_pkg::*;
#(
  parameter int LEVEL = 3,
  parameter int REV   = 1
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [OW-1:0] ofs,
  input  logic [DW-1:0] wdata,
  input  logic          dev_irq,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] pio_q,
  output logic [DW-1:0] fast0_q,
  output logic [DW-1:0] fast1_q,
  output logic          irq_flag
);
  logic [DW-1:0] dma0_q, dma1_q, xbuf_q;
  logic [DW-1:0] fast0_view, fast1_view, dma0_view, dma1_view, xbuf_view;
  logic stat_wr;

  assign stat_wr = wr_en && (ofs == OFS_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= DW'(1);
      pio_q    <= PIO_MODE0;
      fast0_q  <= PIO_MODE0;
      fast1_q  <= PIO_MODE0;
      dma0_q   <= DMA_MODE0;
      dma1_q   <= DMA_MODE0;
      xbuf_q   <= '0;
      irq_flag <= 1'b0;
    end else begin
      if (wr_en) begin
        unique case (ofs)
          OFS_CTRL:  ctrl_q  <= wdata;
          OFS_PIO:   pio_q   <= wdata;
          OFS_FAST0: fast0_q <= wdata;
          OFS_FAST1: fast1_q <= wdata;
          OFS_DMA0:  dma0_q  <= wdata;
          OFS_DMA1:  dma1_q  <= wdata;
          OFS_XBUF:  xbuf_q  <= wdata;
          default: ;
        endcase
      end
      irq_flag <= dev_irq | (irq_flag & (stat_wr ? wdata[0] : 1'b1));
    end
  end

  generate
    if (LEVEL >= 2) begin : g_fast_vis
      assign fast0_view = fast0_q;
      assign fast1_view = fast1_q;
    end else begin : g_fast_hid
      assign fast0_view = '0;
      assign fast1_view = '0;
    end
    if (LEVEL >= 3) begin : g_dma_vis
      assign dma0_view = dma0_q;
      assign dma1_view = dma1_q;
      assign xbuf_view = xbuf_q;
    end else begin : g_dma_hid
      assign dma0_view = '0;
      assign dma1_view = '0;
      assign xbuf_view = '0;
    end
  endgenerate

  always_comb begin
    unique case (ofs)
      OFS_CTRL:  rd_data = ctrl_q;
      OFS_STAT:  rd_data = {4'(LEVEL), 4'(REV), 23'h0, irq_flag};
      OFS_PIO:   rd_data = pio_q;
      OFS_FAST0: rd_data = fast0_view;
      OFS_FAST1: rd_data = fast1_view;
      OFS_DMA0:  rd_data = dma0_view;
      OFS_DMA1:  rd_data = dma1_view;
      OFS_XBUF:  rd_data = xbuf_view;
      default:   rd_data = '0;
    endcase
  end

  // R2
  ctrl_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && ofs == OFS_CTRL) |=> $stable(ctrl_q));

  // R3
  flag_clear_only_by_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !stat_wr) |=> irq_flag);

  // R10
  flag_set_by_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(dev_irq));
endmodule

// File: rtl/ide_timing_sel.sv
module ide_timing_sel
  import ide_reg_pkg::*;
#(
  parameter int LEVEL = 3
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] dev_addr,
  input  logic          dev_done,
  input  logic          dev_we,
  input  logic          head_bit,
  input  logic [DW-1:0] pio_q,
  input  logic [DW-1:0] fast0_q,
  input  logic [DW-1:0] fast1_q,
  output logic [DW-1:0] timing
);
  logic drv_sel_q;
  logic head_wr;

  assign head_wr = dev_done && dev_we && (dev_addr == DEV_HEAD_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)       drv_sel_q <= 1'b0;
    else if (head_wr) drv_sel_q <= head_bit;
  end

  generate
    if (LEVEL >= 2) begin : g_fast
      always_comb begin
        if (dev_addr == DEV_DATA_ADDR) timing = drv_sel_q ? fast1_q : fast0_q;
        else                           timing = pio_q;
      end
    end else begin : g_pio_only
      assign timing = pio_q;
    end
  endgenerate

  // R8
  drv_sel_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !head_wr |=> $stable(drv_sel_q));
endmodule

// File: rtl/ide_reg_front.sv
module ide_reg_front
  import ide_reg_pkg::*;
#(
  parameter int LEVEL = 3,
  parameter int REV   = 1
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  output logic          bus_ready,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          dev_valid,
  input  logic          dev_ready,
  output logic          dev_we,
  output logic [AW-1:0] dev_addr,
  output logic [DW-1:0] dev_wdata,
  input  logic [DW-1:0] dev_rdata,
  output logic [DW-1:0] dev_timing,
  input  logic          dev_irq,
  output logic          dev_rst,
  output logic          irq_out
);
  logic          is_host, host_wr, dev_done, irq_flag;
  logic [DW-1:0] reg_rd, ctrl_q, pio_q, fast0_q, fast1_q;

  assign is_host   = !bus_addr[AW-1];
  assign dev_we    = bus_we;
  assign dev_addr  = bus_addr;
  assign dev_wdata = bus_wdata;
  assign dev_rst   = ctrl_q[CTRL_RST_BIT];
  assign irq_out   = irq_flag && ctrl_q[CTRL_IEN_BIT];
  assign bus_rdata = dev_valid ? dev_rdata : (is_host ? reg_rd : '0);

  ide_bus_seq u_seq (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .is_host(is_host), .fwd_en(ctrl_q[CTRL_EN_BIT]), .dev_ready(dev_ready),
    .bus_ready(bus_ready), .dev_valid(dev_valid), .host_wr(host_wr),
    .dev_done(dev_done)
  );

  ide_reg_file #(.LEVEL(LEVEL), .REV(REV)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr), .ofs(bus_addr[OW-1:0]),
    .wdata(bus_wdata), .dev_irq(dev_irq), .rd_data(reg_rd), .ctrl_q(ctrl_q),
    .pio_q(pio_q), .fast0_q(fast0_q), .fast1_q(fast1_q), .irq_flag(irq_flag)
  );

  ide_timing_sel #(.LEVEL(LEVEL)) u_tsel (
    .clk(clk), .rst_n(rst_n), .dev_addr(bus_addr), .dev_done(dev_done),
    .dev_we(bus_we), .head_bit(bus_wdata[HEAD_DRV_BIT]), .pio_q(pio_q),
    .fast0_q(fast0_q), .fast1_q(fast1_q), .timing(dev_timing)
  );

  // R5
  dev_req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_valid && !dev_ready) |=> $stable(dev_addr) && $stable(dev_timing));
endmodule

// File: tb/ide_reg_front_tb.sv
module ide_reg_front_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 2;
  localparam int NV = 20;

  logic        clk = 0, rst_n = 0;
  logic        bus_valid = 0, bus_we = 0, dev_ready = 0, dev_irq = 0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, dev_rdata = '0;
  logic        bus_ready, dev_valid, dev_we, dev_rst, irq_out;
  logic [6:0]  dev_addr;
  logic [31:0] bus_rdata, dev_wdata, dev_timing;
  logic        l1_ready, l1_dvalid, l1_dwe, l1_drst, l1_irq;
  logic [6:0]  l1_daddr;
  logic [31:0] l1_rdata, l1_dwdata, l1_timing;

  int checks = 0, failures = 0, hs_cnt = 0, cnt = 0;
  logic [31:0] cap_timing, cap_timing1;
  logic [6:0]  cap_addr;
  logic [31:0] rd, rd1;
  int wt;

  always #(CLK_PERIOD/2) clk = ~clk;

  ide_reg_front u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .dev_valid(dev_valid), .dev_ready(dev_ready),
    .dev_we(dev_we), .dev_addr(dev_addr), .dev_wdata(dev_wdata),
    .dev_rdata(dev_rdata), .dev_timing(dev_timing), .dev_irq(dev_irq),
    .dev_rst(dev_rst), .irq_out(irq_out)
  );

  ide_reg_front #(.LEVEL(1)) u_lvl1 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(l1_ready),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(l1_rdata), .dev_valid(l1_dvalid), .dev_ready(dev_ready),
    .dev_we(l1_dwe), .dev_addr(l1_daddr), .dev_wdata(l1_dwdata),
    .dev_rdata(dev_rdata), .dev_timing(l1_timing), .dev_irq(dev_irq),
    .dev_rst(l1_drst), .irq_out(l1_irq)
  );

  // engine model: answers LAT cycles after seeing a request
  always begin
    @(posedge clk); #1;
    if (dev_ready) dev_ready = 0;
    else if (dev_valid) begin
      if (cnt == LAT) begin
        dev_ready = 1; cnt = 0; hs_cnt++;
        cap_timing = dev_timing; cap_timing1 = l1_timing; cap_addr = dev_addr;
        dev_rdata = 32'hC0DE0000 | 32'(dev_addr);
      end else cnt++;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [6:0] a, input logic [31:0] d);
    bus_valid = 1; bus_we = we; bus_addr = a; bus_wdata = d; wt = 0;
    do begin @(negedge clk); wt++; end while (!bus_ready && wt < 1000);
    rd = bus_rdata; rd1 = l1_rdata;
    @(negedge clk);
    bus_valid = 0;
  endtask

  // {we, addr, wdata, expected read}
  localparam logic [71:0] VEC [NV] = '{
    {1'b0, 7'h00, 32'h0, 32'h00000001},  // R1 control
    {1'b0, 7'h04, 32'h0, 32'h31000000},  // R1 status
    {1'b0, 7'h08, 32'h0, 32'h17021C06},  // R1 pio
    {1'b0, 7'h0C, 32'h0, 32'h17021C06},  // R1 fast0
    {1'b0, 7'h10, 32'h0, 32'h17021C06},  // R1 fast1
    {1'b0, 7'h14, 32'h0, 32'h15001504},  // R1 dma0
    {1'b0, 7'h18, 32'h0, 32'h15001504},  // R1 dma1
    {1'b1, 7'h04, 32'hFFFFFFFF, 32'h0},
    {1'b0, 7'h04, 32'h0, 32'h31000000},  // R3 fixed fields
    {1'b1, 7'h08, 32'h11223344, 32'h0},
    {1'b0, 7'h08, 32'h0, 32'h11223344},  // R9
    {1'b1, 7'h0C, 32'h0A0B0C0D, 32'h0},
    {1'b0, 7'h0C, 32'h0, 32'h0A0B0C0D},  // R9
    {1'b1, 7'h10, 32'h01020304, 32'h0},
    {1'b0, 7'h10, 32'h0, 32'h01020304},  // R9
    {1'b1, 7'h1C, 32'hDEADBEEF, 32'h0},
    {1'b0, 7'h1C, 32'h0, 32'hDEADBEEF},  // R9
    {1'b0, 7'h3C, 32'h0, 32'h00000000},  // R9 unmapped
    {1'b0, 7'h40, 32'h0, 32'h00000000},  // R6 disabled read
    {1'b1, 7'h58, 32'h10, 32'h0}         // R6 dropped head write
  };
  localparam string VEC_REQ [NV] = '{"R1","R1","R1","R1","R1","R1","R1","R3","R3",
    "R9","R9","R9","R9","R9","R9","R9","R9","R9","R6","R6"};

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset outputs
    check("R1 dev_rst", 32'(dev_rst), 1);
    check("R1 irq_out", 32'(irq_out), 0);
    check("R1 idle", {30'h0, bus_ready, dev_valid}, 0);

    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i][71], VEC[i][70:64], VEC[i][63:32]);
      check({VEC_REQ[i], " R4 wait"}, wt, 1);
      if (!VEC[i][71]) check(VEC_REQ[i], rd, VEC[i][31:0]);
    end
    check("R6 no handshake", hs_cnt, 0);

    // R2 control bits
    xfer(1, 7'h00, 32'h83);
    check("R2 rst held", 32'(dev_rst), 1);
    xfer(1, 7'h00, 32'h82);
    check("R2 rst released", 32'(dev_rst), 0);

    // R5 forwarded read, R7 pio timing for non-data
    xfer(0, 7'h44, 0);
    check("R5 wait", wt, LAT + 1);
    check("R5 rdata", rd, 32'hC0DE0044);
    check("R5 addr", 32'(cap_addr), 32'h44);
    check("R7 pio", cap_timing, 32'h11223344);

    // R7 data register uses fast0 (drive select stayed 0 after dropped write)
    xfer(0, 7'h40, 0);
    check("R7 fast0", cap_timing, 32'h0A0B0C0D);
    check("R7 level1 pio", cap_timing1, 32'h11223344);

    // R8 snoop drive select
    xfer(1, 7'h58, 32'h10);
    xfer(0, 7'h40, 0);
    check("R8 fast1", cap_timing, 32'h01020304);
    xfer(1, 7'h58, 32'h00);
    xfer(0, 7'h40, 0);
    check("R8 back to fast0", cap_timing, 32'h0A0B0C0D);

    // R9 level hiding
    xfer(0, 7'h0C, 0);
    check("R9 level1 fast hidden", rd1, 0);
    xfer(0, 7'h1C, 0);
    check("R9 level1 buffer hidden", rd1, 0);

    // R10 interrupt
    dev_irq = 1; @(negedge clk); dev_irq = 0;
    check("R10 irq_out", 32'(irq_out), 1);
    xfer(0, 7'h04, 0);
    check("R10 flag read", rd, 32'h31000001);
    xfer(1, 7'h04, 32'h1);
    check("R3 write one keeps", 32'(irq_out), 1);
    xfer(1, 7'h04, 32'h0);
    check("R3 write zero clears", 32'(irq_out), 0);
    dev_irq = 1;
    xfer(1, 7'h04, 32'h0);
    dev_irq = 0;
    check("R10 set wins", 32'(irq_out), 1);

    // R2 interrupt enable off, reset on, forwarding off
    xfer(1, 7'h00, 32'h80);
    check("R2 irq masked", 32'(irq_out), 0);
    xfer(1, 7'h00, 32'h01);
    check("R2 rst set", 32'(dev_rst), 1);
    xfer(0, 7'h44, 0);
    check("R6 off wait", wt, 1);
    check("R6 off read", rd, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule